// File: doc/BRIEF.md
# Microprogram Sequencer with Opcode-Mapped Control Store

This block steps through a 256-word, 32-bit microcode store and drives the datapath's control lines. A control address register (CAR) selects one microword. That word appears on the control outputs in the same cycle, with no register in between. The three lowest bits of each microword are one-hot sequencing bits. One advances CAR by one. One loads CAR from an opcode lookup. One returns CAR to zero, which is the start of the fetch routine.

Each instruction has its own routine, and each routine starts at the base of a 16-word page. The fetch routine sits at words 0 to 2. It reads the instruction word, latches the opcode, and then dispatches. On the dispatch word, the opcode and a datapath condition flag pick the next page. For a conditional jump, the flag picks one of two entry words inside the jump page. Outside the dispatch word, the opcode and the flag have no effect.

The reset input is asynchronous and active-low. Its release passes through a two-stage synchronizer, so CAR leaves word 0 on the third rising edge after the reset input goes high.

Top module: `useq_top`

## Requirements
- R1: While reset is held, and during the two clocks after its release, `car_o` is 0 and `ctrl_o` is 32'h00000009. CAR steps to 1 on the third rising edge after release.
- R2: The fetch routine has three words. Word 0 is 32'h00000009 (bits 3 and 0). Word 1 is 32'h00000011 (bits 4 and 0). Word 2 is 32'h00000002 (bit 1, dispatch). CAR moves 0→1→2.
- R3: On the dispatch word, CAR loads a page base chosen by the opcode. The mapping is 0x02→0x10, 0x01→0x20, 0x03→0x30, 0x04→0x40, 0x06→0x60, 0x07→0x70, 0x09→0x80, 0x0A→0x90, 0x0B→0xA0 and 0x08→0xB0.
- R4: Any opcode not listed in R3 or R5 dispatches to 0x50. The word at 0x50 is 32'h00008104 (bits 15, 8 and 2), and CAR then returns to 0.
- R5: Opcode 0x05 dispatches to 0xF0 when the flag is 1 and to 0xF2 when the flag is 0. Word 0xF0 is 32'h00000041 and word 0xF2 is 32'h00004001. Words 0xF1 and 0xF3 are 32'h00000404 and return CAR to 0.
- R6: The load routine at 0x10..0x14 holds 32'h61, 32'h09, 32'h181, 32'h201 and 32'h404, in that order.
- R7: The two-operand routines share one shape: 32'h61, 32'h09, 32'h81, an operation word, then 32'h404. The operation words are 32'h201 (add, 0x33), 32'h10001 (sub, 0x43), 32'h10000001 (and, 0x63) and 32'h08000001 (or, 0x73). The store routine at 0x20..0x23 holds 32'h61, 32'h1001, 32'h801 and 32'h404.
- R8: The multiply routine at 0xB0..0xB5 holds 32'h61, 32'h09, 32'h81, 32'h01000001, 32'h00040001 and 32'h404.
- R9: The single-word operations hold an operation word and then 32'h404. They are not (0x80: 32'h04000041), shift right (0x90: 32'h00020041) and shift left (0xA0: 32'h02000041).
- R10: `ctrl_o` always equals the store word at the current `car_o`, in the same cycle.
- R11: CAR changes only as the sequencing bits say. Bit 0 means +1, bit 1 means mapped load and bit 2 means clear. Every reachable word sets exactly one of these bits.
- R12: Opcode and flag values presented in any cycle other than the dispatch word have no effect on CAR or on `ctrl_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| opcode_i | input | 8 | Opcode held in the datapath's instruction register |
| flag_i | input | 1 | Datapath condition flag for the conditional jump |
| ctrl_o | output | 32 | Current microword, i.e. the control lines |
| car_o | output | 8 | Current control address |

## Verification
A wrong CAR value shows up on `car_o` in the very next cycle. It also shows up on `ctrl_o` in the same cycle, because the store output has no register. A bad mapping or a missed flag therefore shows at the first control word of the wrong routine. A corrupted store word differs from the expected constant in the cycle its address is visited. If the bad word is a sequencing word, the error also spreads into the CAR path one cycle later. A reference model in the bench tracks CAR under random opcodes and flags held for whole instructions or changed every cycle, and compares every cycle.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int CW  = 32;
  localparam int AW  = 8;
  localparam int OPW = 8;
  localparam int PGW = 4;

  // sequencing bits (one-hot within a word)
  localparam int B_INC    = 0;
  localparam int B_MAP    = 1;
  localparam int B_CLR    = 2;
  // datapath bits
  localparam int B_RD     = 3;
  localparam int B_IR     = 4;
  localparam int B_MARMBR = 5;
  localparam int B_PCINC  = 6;
  localparam int B_BR     = 7;
  localparam int B_ACCCLR = 8;
  localparam int B_ADD    = 9;
  localparam int B_MARPC  = 10;
  localparam int B_WR     = 11;
  localparam int B_MBRACC = 12;
  localparam int B_PCMBR  = 14;
  localparam int B_PCCLR  = 15;
  localparam int B_SUB    = 16;
  localparam int B_SHR    = 17;
  localparam int B_MULH   = 18;
  localparam int B_MULL   = 24;
  localparam int B_SHL    = 25;
  localparam int B_NOT    = 26;
  localparam int B_OR     = 27;
  localparam int B_AND    = 28;

  // routine page bases
  localparam logic [AW-1:0] PG_FETCH = 8'h00;
  localparam logic [AW-1:0] PG_LOAD  = 8'h10;
  localparam logic [AW-1:0] PG_STORE = 8'h20;
  localparam logic [AW-1:0] PG_ADD   = 8'h30;
  localparam logic [AW-1:0] PG_SUB   = 8'h40;
  localparam logic [AW-1:0] PG_HALT  = 8'h50;
  localparam logic [AW-1:0] PG_AND   = 8'h60;
  localparam logic [AW-1:0] PG_OR    = 8'h70;
  localparam logic [AW-1:0] PG_NOT   = 8'h80;
  localparam logic [AW-1:0] PG_SHR   = 8'h90;
  localparam logic [AW-1:0] PG_SHL   = 8'hA0;
  localparam logic [AW-1:0] PG_MUL   = 8'hB0;
  localparam logic [AW-1:0] PG_JMP   = 8'hF0;
  localparam logic [AW-1:0] JMP_TAKE = 8'hF2;

  typedef enum logic [OPW-1:0] {
    OP_STORE = 8'h01, OP_LOAD = 8'h02, OP_ADD = 8'h03, OP_SUB = 8'h04,
    OP_JMPZ  = 8'h05, OP_AND  = 8'h06, OP_OR  = 8'h07, OP_MUL = 8'h08,
    OP_NOT   = 8'h09, OP_SHR  = 8'h0A, OP_SHL = 8'h0B
  } opcode_e;

  function automatic logic [CW-1:0] bm(input int b);
    return CW'(1) << b;
  endfunction

  // Store contents, built from routine shapes rather than listed per word.
  function automatic logic [CW-1:0] ucode_word(input logic [AW-1:0] a);
    logic [PGW-1:0] pg;
    logic [PGW-1:0] off;
    logic [CW-1:0]  w_opnd, w_read, w_br, w_ret, alu, w;
    pg     = a[AW-1:AW-PGW];
    off    = a[PGW-1:0];
    w_opnd = bm(B_MARMBR) | bm(B_PCINC) | bm(B_INC);
    w_read = bm(B_RD) | bm(B_INC);
    w_br   = bm(B_BR) | bm(B_INC);
    w_ret  = bm(B_MARPC) | bm(B_CLR);
    w      = '0;
    case (pg)
      4'h3:    alu = bm(B_ADD);
      4'h4:    alu = bm(B_SUB);
      4'h6:    alu = bm(B_AND);
      4'h7:    alu = bm(B_OR);
      4'h8:    alu = bm(B_NOT);
      4'h9:    alu = bm(B_SHR);
      4'hA:    alu = bm(B_SHL);
      default: alu = '0;
    endcase
    case (pg)
      4'h0: begin
        case (off)
          4'd0:    w = w_read;
          4'd1:    w = bm(B_IR) | bm(B_INC);
          4'd2:    w = bm(B_MAP);
          default: w = '0;
        endcase
      end
      4'h1: begin
        case (off)
          4'd0:    w = w_opnd;
          4'd1:    w = w_read;
          4'd2:    w = bm(B_ACCCLR) | bm(B_BR) | bm(B_INC);
          4'd3:    w = bm(B_ADD) | bm(B_INC);
          4'd4:    w = w_ret;
          default: w = '0;
        endcase
      end
      4'h2: begin
        case (off)
          4'd0:    w = w_opnd;
          4'd1:    w = bm(B_MBRACC) | bm(B_INC);
          4'd2:    w = bm(B_WR) | bm(B_INC);
          4'd3:    w = w_ret;
          default: w = '0;
        endcase
      end
      4'h3, 4'h4, 4'h6, 4'h7: begin
        case (off)
          4'd0:    w = w_opnd;
          4'd1:    w = w_read;
          4'd2:    w = w_br;
          4'd3:    w = alu | bm(B_INC);
          4'd4:    w = w_ret;
          default: w = '0;
        endcase
      end
      4'h5: begin
        if (off == 4'd0) w = bm(B_ACCCLR) | bm(B_PCCLR) | bm(B_CLR);
      end
      4'h8, 4'h9, 4'hA: begin
        case (off)
          4'd0:    w = alu | bm(B_PCINC) | bm(B_INC);
          4'd1:    w = w_ret;
          default: w = '0;
        endcase
      end
      4'hB: begin
        case (off)
          4'd0:    w = w_opnd;
          4'd1:    w = w_read;
          4'd2:    w = w_br;
          4'd3:    w = bm(B_MULL) | bm(B_INC);
          4'd4:    w = bm(B_MULH) | bm(B_INC);
          4'd5:    w = w_ret;
          default: w = '0;
        endcase
      end
      4'hF: begin
        case (off)
          4'd0:    w = bm(B_PCINC) | bm(B_INC);
          4'd1:    w = w_ret;
          4'd2:    w = bm(B_PCMBR) | bm(B_INC);
          4'd3:    w = w_ret;
          default: w = '0;
        endcase
      end
      default: w = '0;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/useq_rst_sync.sv
module useq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sr_q[STAGES-1];
endmodule

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
(
  input  logic [AW-1:0] addr,
  output logic [CW-1:0] word
);
  always_comb word = ucode_word(addr);
endmodule

// File: rtl/useq_map.sv
module useq_map
  import useq_pkg::*;
(
  input  logic [OPW-1:0] opcode,
  input  logic           flag,
  output logic [AW-1:0]  target
);
  always_comb begin
    case (opcode)
      OP_LOAD:  target = PG_LOAD;
      OP_STORE: target = PG_STORE;
      OP_ADD:   target = PG_ADD;
      OP_SUB:   target = PG_SUB;
      OP_JMPZ:  target = flag ? PG_JMP : JMP_TAKE;
      OP_AND:   target = PG_AND;
      OP_OR:    target = PG_OR;
      OP_MUL:   target = PG_MUL;
      OP_NOT:   target = PG_NOT;
      OP_SHR:   target = PG_SHR;
      OP_SHL:   target = PG_SHL;
      default:  target = PG_HALT;
    endcase
  end
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
(
  input  logic [AW-1:0] car,
  input  logic [2:0]    seq,
  input  logic [AW-1:0] target,
  output logic [AW-1:0] car_next,
  output logic          car_en
);
  always_comb begin
    car_en   = |seq;
    car_next = car;
    if (seq[B_CLR])      car_next = PG_FETCH;
    else if (seq[B_MAP]) car_next = target;
    else if (seq[B_INC]) car_next = car + AW'(1);
  end
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] opcode_i,
  input  logic           flag_i,
  output logic [CW-1:0]  ctrl_o,
  output logic [AW-1:0]  car_o
);
  logic          rst_sync_n;
  logic [AW-1:0] car_q, car_d, target;
  logic          car_en;

  useq_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  useq_store u_store (.addr(car_q), .word(ctrl_o));

  useq_map u_map (.opcode(opcode_i), .flag(flag_i), .target(target));

  useq_next u_next (
    .car(car_q), .seq(ctrl_o[2:0]), .target(target),
    .car_next(car_d), .car_en(car_en)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  car_q <= PG_FETCH;
    else if (car_en)  car_q <= car_d;
  end

  assign car_o = car_q;

  // R11: one sequencing bit per word
  a_r11_onehot_seq: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $countones(ctrl_o[2:0]) == 1);
  // R11: increment advances by one
  a_r11_inc: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ctrl_o[B_INC] |=> car_o == $past(car_o) + 8'd1);
  // R11: clear returns to fetch
  a_r11_clr: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ctrl_o[B_CLR] |=> car_o == 8'h00);
  // R2: dispatch lives at word 2
  a_r2_dispatch: assert property (@(posedge clk) disable iff (!rst_sync_n)
    car_o == 8'h02 |-> ctrl_o[B_MAP]);
  // R3: non-jump dispatch lands on a page base
  a_r3_page_base: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (car_o == 8'h02 && opcode_i != 8'h05) |=> car_o[3:0] == 4'h0);
  // R5: flag 0 takes the jump
  a_r5_jump_taken: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (car_o == 8'h02 && opcode_i == 8'h05 && !flag_i) |=> car_o == 8'hF2);
  // R5: flag 1 skips
  a_r5_jump_skip: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (car_o == 8'h02 && opcode_i == 8'h05 && flag_i) |=> car_o == 8'hF0);
endmodule

// File: tb/useq_top_bench.sv
module useq_top_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic [7:0]  opcode;
  logic        flag;
  logic [31:0] ctrl;
  logic [7:0]  car;

  useq_top u_useq_top (
    .clk(clk), .rst_n(rst_n), .opcode_i(opcode), .flag_i(flag),
    .ctrl_o(ctrl), .car_o(car)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  int    car_m = 0;
  int    rel = 0;
  bit    armed = 0;
  bit    done = 0;
  string ctag = "R1";

  function automatic logic [31:0] exp_word(input int a);
    case (a)
      'h00: return 32'h00000009;  'h01: return 32'h00000011;  'h02: return 32'h00000002;
      'h10: return 32'h00000061;  'h11: return 32'h00000009;  'h12: return 32'h00000181;
      'h13: return 32'h00000201;  'h14: return 32'h00000404;
      'h20: return 32'h00000061;  'h21: return 32'h00001001;  'h22: return 32'h00000801;
      'h23: return 32'h00000404;
      'h30: return 32'h00000061;  'h31: return 32'h00000009;  'h32: return 32'h00000081;
      'h33: return 32'h00000201;  'h34: return 32'h00000404;
      'h40: return 32'h00000061;  'h41: return 32'h00000009;  'h42: return 32'h00000081;
      'h43: return 32'h00010001;  'h44: return 32'h00000404;
      'h50: return 32'h00008104;
      'h60: return 32'h00000061;  'h61: return 32'h00000009;  'h62: return 32'h00000081;
      'h63: return 32'h10000001;  'h64: return 32'h00000404;
      'h70: return 32'h00000061;  'h71: return 32'h00000009;  'h72: return 32'h00000081;
      'h73: return 32'h08000001;  'h74: return 32'h00000404;
      'h80: return 32'h04000041;  'h81: return 32'h00000404;
      'h90: return 32'h00020041;  'h91: return 32'h00000404;
      'hA0: return 32'h02000041;  'hA1: return 32'h00000404;
      'hB0: return 32'h00000061;  'hB1: return 32'h00000009;  'hB2: return 32'h00000081;
      'hB3: return 32'h01000001;  'hB4: return 32'h00040001;  'hB5: return 32'h00000404;
      'hF0: return 32'h00000041;  'hF1: return 32'h00000404;
      'hF2: return 32'h00004001;  'hF3: return 32'h00000404;
      default: return 32'h0;
    endcase
  endfunction

  function automatic int exp_map(input int op, input bit f);
    case (op)
      'h02: return 'h10;  'h01: return 'h20;  'h03: return 'h30;  'h04: return 'h40;
      'h05: return f ? 'hF0 : 'hF2;
      'h06: return 'h60;  'h07: return 'h70;  'h08: return 'hB0;  'h09: return 'h80;
      'h0A: return 'h90;  'h0B: return 'hA0;
      default: return 'h50;
    endcase
  endfunction

  function automatic string region(input int a);
    if (a <= 2)                            return "R2";
    if (a >= 'hF0)                         return "R5";
    if (a == 'h50)                         return "R4";
    if (a >= 'h10 && a < 'h20)             return "R6";
    if (a >= 'hB0)                         return "R8";
    if (a >= 'h80)                         return "R9";
    return "R7";
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input bit r, input logic [7:0] op, input bit f,
                      input string phase);
    logic [31:0] w;
    @(negedge clk);
    if (armed) begin
      chk(car === car_m[7:0], ctag, {24'h0, car}, car_m);
      chk(ctrl === exp_word(car_m), (ctag == "R1") ? "R1" : region(car_m),
          ctrl, exp_word(car_m));
      chk(ctrl === exp_word(int'(car)), "R10", ctrl, exp_word(int'(car)));
    end
    armed  = 1'b1;
    rst_n  = r;
    opcode = op;
    flag   = f;
    if (!r) begin
      rel = 0; car_m = 0; ctag = "R1";
    end else if (rel < 2) begin
      rel++; car_m = 0; ctag = "R1";
    end else begin
      w    = exp_word(car_m);
      ctag = phase;
      if (w[2])      car_m = 0;
      else if (w[1]) begin car_m = exp_map(op, f); ctag = "R3"; end
      else if (w[0]) car_m = (car_m + 1) % 256;
    end
  endtask

  initial begin
    rst_n = 1'b0; opcode = 8'h00; flag = 1'b0;
    // R1: reset state, then release
    repeat (4) step(1'b0, 8'h02, 1'b0, "R1");
    // R3 R4 R5 R6 R7 R8 R9 R11: each opcode held for whole instructions
    foreach (ops_list[i]) begin
      repeat (14) step(1'b1, ops_list[i], 1'b1, "R11");
      repeat (14) step(1'b1, ops_list[i], 1'b0, "R11");
    end
    // R1: reset in mid-routine
    repeat (6) step(1'b1, 8'h08, 1'b0, "R11");
    repeat (2) step(1'b0, 8'h08, 1'b0, "R1");
    repeat (8) step(1'b1, 8'h05, 1'b0, "R11");
    // R12: opcode and flag change every cycle
    for (int k = 0; k < 3000; k++)
      step(1'b1, 8'($urandom_range(0, 15)), 1'($urandom), "R12");
    step(1'b1, 8'h00, 1'b0, "R12");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  logic [7:0] ops_list [15] = '{8'h02, 8'h01, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07,
                                8'h08, 8'h09, 8'h0A, 8'h0B, 8'h00, 8'h0C, 8'h5A, 8'hFF};

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule